// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches the running time of day (seconds, minutes, hours and day of month, each in packed BCD) and compares it against four programmable alarm bytes. Every alarm byte has its own mask bit. A field whose mask bit is clear must equal the live value for an alarm. A field whose mask bit is set drops out of the comparison. The comparison is evaluated only on the cycle where the seconds tick input is high. When every unmasked field agrees, the block emits a one-cycle match pulse and sets a sticky alarm flag.

Software reaches the alarm bytes and the flag over a small byte bus with an address, write strobe and read strobe. Read data is combinational. The flag is read-only. Reading the status address returns the flag and clears it at the following clock edge. A new match that arrives in the same cycle as that read wins, so no alarm is lost. A match that persists over many ticks raises only one event. If every field is masked, an event fires on every tick.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset, match_pulse and alarm_flag are 0 and all four alarm bytes read back as 0x00.
- R2: Alarm bytes sit at address 1 (seconds), 2 (minutes), 3 (hours) and 4 (date). Bit 7 of each byte is the mask bit. Seconds and minutes keep bits 6..0 as BCD (tens in 6..4, units in 3..0). Hours and date keep bits 5..0 (tens in 5..4, units in 3..0). Bits that are not kept read back as 0, and addresses 5 to 7 read as 0x00.
- R3: A field whose mask bit is 1 has no influence on the match, whatever its live value.
- R4: On a clock edge where tick is 1 and every unmasked field equals its alarm value, match_pulse is 1 for the following cycle and alarm_flag is 1 from then on. With tick at 0, no event occurs.
- R5: While at least one field is unmasked, a match that holds over consecutive ticks produces an event only on the first of those ticks. A tick without a match re-arms detection.
- R6: When all four mask bits are 1, every tick produces an event.
- R7: alarm_flag stays at 1 until the status register is read.
- R8: Reading address 0 returns alarm_flag in bit 6 and 0 in every other bit. The flag clears at the edge that ends the read cycle.
- R9: If a status read and a new event occur on the same edge, alarm_flag is 1 after that edge.
- R10: Writes to address 0 or to addresses 5 to 7 change neither the flag nor any alarm byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle seconds tick that qualifies a comparison |
| cur_sec | input | 7 | Live seconds, BCD |
| cur_min | input | 7 | Live minutes, BCD |
| cur_hour | input | 6 | Live hours, BCD |
| cur_date | input | 6 | Live day of month, BCD |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 3 | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational |
| match_pulse | output | 1 | One-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The assertions assume that tick, wr_en and rd_en are clean synchronous single-cycle strobes and that the bus address is stable across a strobe. The checker does not rely on the live time being legal BCD. The stimulus changes all inputs only on the falling clock edge and raises each strobe for exactly one cycle. It sweeps all sixteen mask combinations against all sixteen patterns of matching and non-matching fields. The bench keeps its own record of the previous tick's match to predict re-arming.

// File: rtl/bca_pkg.sv
package bca_pkg;
  localparam int NF = 4;

  // Value width for each field: seconds, minutes, hours, date
  function automatic int fld_width(input int i);
    return (i < 2) ? 7 : 6;
  endfunction

  // Bit offset of each field inside the packed live-time vector
  function automatic int fld_offset(input int i);
    int acc;
    acc = 0;
    for (int k = 0; k < i; k++) acc += fld_width(k);
    return acc;
  endfunction

  // Bits kept in a stored alarm byte: mask bit plus value bits
  function automatic logic [7:0] fld_keep(input int i);
    return 8'h80 | 8'((1 << fld_width(i)) - 1);
  endfunction
endpackage

// File: rtl/bca_field_cmp.sv
module bca_field_cmp #(
  parameter int VW = 7
) (
  input  logic          msk,
  input  logic [VW-1:0] alm_val,
  input  logic [VW-1:0] cur_val,
  output logic          hit
);
  always_comb begin
    hit = msk | (alm_val == cur_val);
  end
endmodule

// File: rtl/bca_regs.sv
module bca_regs
  import bca_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output logic [NF-1:0][7:0]    alm_q
);
  logic [NF-1:0][7:0] alm_d;

  always_comb begin
    alm_d = alm_q;
    for (int i = 0; i < NF; i++) begin
      if (wr_en && (addr == ADDR_W'(i + 1))) alm_d[i] = wdata & fld_keep(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_q <= '0;
    else        alm_q <= alm_d;
  end
endmodule

// File: rtl/bca_event.sv
module bca_event (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic all_hit,
  input  logic all_masked,
  input  logic flag_clr,
  output logic match_pulse,
  output logic alarm_flag
);
  logic prev_q, prev_d;
  logic pulse_d, flag_d, fire;

  always_comb begin
    fire    = tick & all_hit & (all_masked | ~prev_q);
    prev_d  = tick ? all_hit : prev_q;
    pulse_d = fire;
    if (fire)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = alarm_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      match_pulse <= 1'b0;
      alarm_flag  <= 1'b0;
    end else begin
      prev_q      <= prev_d;
      match_pulse <= pulse_d;
      alarm_flag  <= flag_d;
    end
  end
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bca_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_date,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              match_pulse,
  output logic              alarm_flag
);
  localparam int CUR_W = fld_offset(NF);

  logic [NF-1:0][7:0] alm_q;
  logic [CUR_W-1:0]   cur_all;
  logic [NF-1:0]      hit_v;
  logic [NF-1:0]      msk_v;
  logic               flag_clr;

  assign cur_all  = {cur_date, cur_hour, cur_min, cur_sec};
  assign flag_clr = rd_en && (addr == '0);

  bca_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .alm_q (alm_q)
  );

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam int W   = fld_width(g);
    localparam int OFF = fld_offset(g);
    assign msk_v[g] = alm_q[g][7];
    bca_field_cmp #(.VW(W)) u_cmp (
      .msk     (alm_q[g][7]),
      .alm_val (alm_q[g][W-1:0]),
      .cur_val (cur_all[OFF+W-1:OFF]),
      .hit     (hit_v[g])
    );
  end

  bca_event u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .all_hit     (&hit_v),
    .all_masked  (&msk_v),
    .flag_clr    (flag_clr),
    .match_pulse (match_pulse),
    .alarm_flag  (alarm_flag)
  );

  always_comb begin
    rdata = 8'h00;
    if (addr == '0) rdata = {1'b0, alarm_flag, 6'b0};
    for (int i = 0; i < NF; i++) begin
      if (addr == ADDR_W'(i + 1)) rdata = alm_q[i];
    end
  end
endmodule

// File: rtl/bca_alarm_chk.sv
module bca_alarm_chk
  import bca_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic               match_pulse,
  input logic               alarm_flag,
  input logic [NF-1:0][7:0] alm_q
);
  logic alm_wr;
  assign alm_wr = wr_en && (addr != '0) && (addr <= ADDR_W'(NF));

  assert_pulse_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> alarm_flag);

  assert_pulse_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !match_pulse);

  assert_flag_rises_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> match_pulse);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !(rd_en && addr == '0)) |=> alarm_flag);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0) |=> (match_pulse || !alarm_flag));

  assert_alm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_wr |=> $stable(alm_q));
endmodule

bind bcd_alarm_cmp bca_alarm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .match_pulse (match_pulse),
  .alarm_flag  (alarm_flag),
  .alm_q       (alm_q)
);

// File: tb/bcd_alarm_cmp_bench.sv
module bcd_alarm_cmp_bench;
  logic       clk, rst_n, tick, wr_en, rd_en;
  logic [6:0] cur_sec, cur_min;
  logic [5:0] cur_hour, cur_date;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       match_pulse, alarm_flag;

  int total, bad;
  logic prev_m;

  localparam logic [7:0] AV [4] = '{8'h45, 8'h37, 8'h23, 8'h31};
  localparam logic [7:0] NV [4] = '{8'h12, 8'h08, 8'h11, 8'h05};

  bcd_alarm_cmp u_bcd_alarm_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .match_pulse(match_pulse), .alarm_flag(alarm_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // pat bit i set: field i equals alarm value; else a differing value
  task automatic set_time(input int pat);
    cur_sec  = pat[0] ? AV[0][6:0] : NV[0][6:0];
    cur_min  = pat[1] ? AV[1][6:0] : NV[1][6:0];
    cur_hour = pat[2] ? AV[2][5:0] : NV[2][5:0];
    cur_date = pat[3] ? AV[3][5:0] : NV[3][5:0];
  endtask

  task automatic do_tick(input int pat, input logic with_rd);
    @(negedge clk);
    set_time(pat);
    tick = 1'b1;
    if (with_rd) begin rd_en = 1'b1; addr = 3'd0; end
    @(negedge clk);
    tick = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    total = 0; bad = 0; prev_m = 1'b0;
    tick = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    set_time(0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pulse", {7'b0, match_pulse}, 8'h00);
    chk("R1 flag", {7'b0, alarm_flag}, 8'h00);
    rst_n = 1'b1;
    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), d);
      chk("R1 alarm byte", d, 8'h00);
    end

    // R2: layout of kept bits
    for (int a = 1; a <= 4; a++) wr(3'(a), 8'hFF);
    for (int a = 1; a <= 7; a++) begin
      rd(3'(a), d);
      chk("R2 readback", d, (a <= 2) ? 8'hFF : (a <= 4) ? 8'hBF : 8'h00);
    end

    // Sweep masks x match patterns (R3, R4, R5, R6, R7, R8)
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 4; f++) wr(3'(f + 1), {m[f], AV[f][6:0]});
      for (int p = 0; p < 16; p++) begin
        logic allm, exp_ev;
        allm   = ((p | m) & 15) == 15;
        exp_ev = allm && ((m == 15) || !prev_m);
        prev_m = allm;
        do_tick(p, 1'b0);
        chk("R3 R4 R5 R6 pulse", {7'b0, match_pulse}, {7'b0, exp_ev});
        chk("R4 R7 flag", {7'b0, alarm_flag}, {7'b0, exp_ev});
        @(negedge clk);
        chk("R4 pulse width", {7'b0, match_pulse}, 8'h00);
        chk("R7 flag sticky", {7'b0, alarm_flag}, {7'b0, exp_ev});
        rd(3'd0, d);
        chk("R8 status read", d, exp_ev ? 8'h40 : 8'h00);
        chk("R8 cleared", {7'b0, alarm_flag}, 8'h00);
      end
    end

    // R4: match present without tick gives no event
    for (int f = 0; f < 4; f++) wr(3'(f + 1), {1'b0, AV[f][6:0]});
    do_tick(0, 1'b0); prev_m = 1'b0;
    @(negedge clk); set_time(15);
    repeat (3) @(negedge clk);
    chk("R4 no tick", {7'b0, alarm_flag}, 8'h00);

    // R9: read coinciding with new event keeps flag
    do_tick(15, 1'b1);
    chk("R9 coincident pulse", {7'b0, match_pulse}, 8'h01);
    chk("R9 flag kept", {7'b0, alarm_flag}, 8'h01);

    // R10: writes to status and unused addresses ignored
    wr(3'd0, 8'h00);
    chk("R10 flag after write", {7'b0, alarm_flag}, 8'h01);
    wr(3'd5, 8'hFF); wr(3'd7, 8'hFF); wr(3'd0, 8'hFF);
    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), d);
      chk("R10 alarm byte kept", d, {1'b0, AV[a-1][6:0]});
    end
    rd(3'd0, d);
    chk("R10 R8 status", d, 8'h40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule